// File: doc/BRIEF.md
# Shadowed Motor-Control PWM Channel

This block is one pulse-width modulation channel for motor drives. A free-running counter runs in one of two shapes. The first is a sawtooth that wraps back to zero. The second is a triangle that climbs to the period value and falls back to zero. Each count is compared against a compare value to drive two complementary outputs, A and B. An optional dead-time guard holds back each output's switch-on by a programmed number of clocks. Because of it, the two switches of a half-bridge are never driven on together.

Software reaches the channel through a small synchronous register port. The mode word cannot be written in place. Bits are raised by writing ones to a set alias and lowered by writing ones to a clear alias, so separate agents can change separate bits without a read-modify-write. Period, compare and dead-time values are first written to staging registers. They move into the working registers only at the end of a PWM cycle, so a running waveform never sees a half-applied setting. A hold bit freezes the working registers for as long as the counter runs.

There is no streaming data path in this block. Every pin is a plain control or status signal, so no valid/ready handshake applies.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset the mode word, the staging registers and the working registers are all 0, and both outputs are low.
- R2: A write to the mode word's own address (0x0) has no effect on it.
- R3: Writing to the set alias (0x1) ORs bits 4:0 of the write data into the mode word. Writing to the clear alias (0x2) clears the bits written as one. Mode bits are: bit 0 run, bit 1 triangle counting, bit 2 inverted polarity, bit 3 dead-time enable, bit 4 update hold. Bits 7:5 read as 0.
- R4: In sawtooth mode (bit 1 = 0) the counter steps 0,1,...,P and then returns to 0, so one cycle lasts P+1 clocks.
- R5: In triangle mode (bit 1 = 1) the counter steps 0 up to P and back down to 0, so one cycle lasts 2P clocks.
- R6: With bit 2 = 0 the active output level is high and the passive level is low. With bit 2 = 1 both levels are inverted.
- R7: Output A is active while the count is at or above the compare value. Output B is active otherwise. Both are registered, and A and B are never active in the same clock.
- R8: With bit 3 = 1, each output turns active only after its raw condition has held for the dead-time count in clocks. With bit 3 = 0 no delay is added.
- R9: While running with bit 4 = 0, the working period, compare and dead-time registers take the staged values at the end of each cycle: the wrap to 0 in sawtooth mode, or the arrival at 0 on the way down in triangle mode.
- R10: While running with bit 4 = 1, the working registers keep their values whatever is written to the staging registers.
- R11: While bit 0 = 0, the counter holds at 0, both outputs sit at the passive level, and the working registers follow the staging registers one clock later.
- R12: Read addresses: 0x0 mode word, 0x3/0x4/0x5 staged period/compare/dead time, 0x6/0x7/0x8 working period/compare/dead time, 0x9 counter. Read data is registered one clock after the address. The set and clear aliases and all unlisted addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register port address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Registered read data for the address of the previous clock |
| pwm_a | output | 1 | Output A pin level |
| pwm_b | output | 1 | Output B pin level, complementary to A |

## Verification
The assertions check, on every cycle, the properties that are local in time. The mode word changes only on alias writes, and its reserved bits stay zero. The counter wraps or turns around at the period. The two outputs are never active together, and an output stays off while its dead-time delay is still counting. The working registers stay fixed while the hold bit is set in a running channel, and they follow the staging registers while stopped. Only the bench's scenarios can show the properties of a whole waveform. These are the duty split between A and B over a full cycle in each mode, the cycle length after a period change has been taken up at a boundary, and the pin levels under each polarity.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] ADR_MODE  = 4'h0;
  localparam logic [REG_AW-1:0] ADR_SET   = 4'h1;
  localparam logic [REG_AW-1:0] ADR_CLR   = 4'h2;
  localparam logic [REG_AW-1:0] ADR_SPER  = 4'h3;
  localparam logic [REG_AW-1:0] ADR_SCMP  = 4'h4;
  localparam logic [REG_AW-1:0] ADR_SDT   = 4'h5;
  localparam logic [REG_AW-1:0] ADR_WPER  = 4'h6;
  localparam logic [REG_AW-1:0] ADR_WCMP  = 4'h7;
  localparam logic [REG_AW-1:0] ADR_WDT   = 4'h8;
  localparam logic [REG_AW-1:0] ADR_COUNT = 4'h9;

  localparam int MODE_BITS = 5;
  localparam int MODE_W    = 8;

  localparam int B_RUN  = 0;
  localparam int B_TRI  = 1;
  localparam int B_INV  = 2;
  localparam int B_DTEN = 3;
  localparam int B_HOLD = 4;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  work_per,
  input  logic [CNT_W-1:0]  work_cmp,
  input  logic [DT_W-1:0]   work_dt,
  output logic              m_run,
  output logic              m_tri,
  output logic              m_inv,
  output logic              m_dten,
  output logic              m_hold,
  output logic [CNT_W-1:0]  stg_per,
  output logic [CNT_W-1:0]  stg_cmp,
  output logic [DT_W-1:0]   stg_dt,
  output logic [CNT_W-1:0]  rdata
);
  logic [MODE_BITS-1:0] mode_q;
  logic [MODE_W-1:0]    mode_word;
  logic [CNT_W-1:0]     rdata_d;
  logic                 alias_hit;

  assign mode_word = {{(MODE_W-MODE_BITS){1'b0}}, mode_q};
  assign alias_hit = (addr == ADR_SET) || (addr == ADR_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr && addr == ADR_SET) begin
      mode_q <= mode_q | wdata[MODE_BITS-1:0];
    end else if (wr && addr == ADR_CLR) begin
      mode_q <= mode_q & ~wdata[MODE_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_per <= '0;
      stg_cmp <= '0;
      stg_dt  <= '0;
    end else if (wr) begin
      if (addr == ADR_SPER) stg_per <= wdata;
      if (addr == ADR_SCMP) stg_cmp <= wdata;
      if (addr == ADR_SDT)  stg_dt  <= wdata[DT_W-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      ADR_MODE:  rdata_d = CNT_W'(mode_word);
      ADR_SPER:  rdata_d = stg_per;
      ADR_SCMP:  rdata_d = stg_cmp;
      ADR_SDT:   rdata_d = CNT_W'(stg_dt);
      ADR_WPER:  rdata_d = work_per;
      ADR_WCMP:  rdata_d = work_cmp;
      ADR_WDT:   rdata_d = CNT_W'(work_dt);
      ADR_COUNT: rdata_d = count;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  assign m_run  = mode_q[B_RUN];
  assign m_tri  = mode_q[B_TRI];
  assign m_inv  = mode_q[B_INV];
  assign m_dten = mode_q[B_DTEN];
  assign m_hold = mode_q[B_HOLD];

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && alias_hit) |=> $stable(mode_q));

  // R3
  mode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_MODE) |=> (rdata[CNT_W-1:MODE_BITS] == '0));

  // R12
  alias_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alias_hit |=> (rdata == '0));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tri_mode,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             cyc_end
);
  logic falling;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      count   <= '0;
      falling <= 1'b0;
    end else if (!tri_mode) begin
      falling <= 1'b0;
      if (count >= period) count <= '0;
      else                 count <= count + 1'b1;
    end else if (!falling) begin
      if (count >= period) begin
        falling <= 1'b1;
        count   <= (count == '0) ? '0 : count - 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end else begin
      if (count == '0) begin
        falling <= 1'b0;
        count   <= (period == '0) ? '0 : CNT_W'(1);
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  assign cyc_end = run && (tri_mode ? (falling && count == '0) : (count >= period));

  // R4
  saw_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tri_mode && count >= period) |=> (count == '0));

  // R5
  tri_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tri_mode && falling && count == '0) |=> (!falling && count <= CNT_W'(1)));

  // R11
  stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             cyc_end,
  input  logic [CNT_W-1:0] stg_per,
  input  logic [CNT_W-1:0] stg_cmp,
  input  logic [DT_W-1:0]  stg_dt,
  output logic [CNT_W-1:0] work_per,
  output logic [CNT_W-1:0] work_cmp,
  output logic [DT_W-1:0]  work_dt
);
  logic take;

  assign take = !run || (cyc_end && !hold);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_per <= '0;
      work_cmp <= '0;
      work_dt  <= '0;
    end else if (take) begin
      work_per <= stg_per;
      work_cmp <= stg_cmp;
      work_dt  <= stg_dt;
    end
  end

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold) |=> ($stable(work_per) && $stable(work_cmp) && $stable(work_dt)));

  // R11
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (work_per == $past(stg_per) && work_cmp == $past(stg_cmp)));
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             inv,
  input  logic             dt_en,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp,
  input  logic [DT_W-1:0]  dt,
  output logic             pin_a,
  output logic             pin_b
);
  localparam int LANES = 2;

  logic [LANES-1:0] raw;
  logic [LANES-1:0] act;
  logic [DT_W-1:0]  guard;
  logic             above;

  assign above  = count >= cmp;
  assign raw[0] = run && above;
  assign raw[1] = run && !above;
  assign guard  = dt_en ? dt : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DT_W-1:0] wait_q;

    always_ff @(posedge clk) begin
      if (!rst_n || !raw[g]) begin
        wait_q <= '0;
        act[g] <= 1'b0;
      end else if (wait_q >= guard) begin
        act[g] <= 1'b1;
      end else begin
        wait_q <= wait_q + 1'b1;
        act[g] <= 1'b0;
      end
    end

    // R8
    guard_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_en && raw[g] && wait_q < dt) |=> !act[g]);
  end

  assign pin_a = act[0] ^ inv;
  assign pin_b = act[1] ^ inv;

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act[0] && act[1]));

  // R11
  stop_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (act == '0));
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              pwm_a,
  output logic              pwm_b
);
  logic             m_run, m_tri, m_inv, m_dten, m_hold;
  logic [CNT_W-1:0] stg_per, stg_cmp, work_per, work_cmp, count;
  logic [DT_W-1:0]  stg_dt, work_dt;
  logic             cyc_end;

  pwm_regfile #(.CNT_W(CNT_W), .DT_W(DT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .count(count), .work_per(work_per), .work_cmp(work_cmp), .work_dt(work_dt),
    .m_run(m_run), .m_tri(m_tri), .m_inv(m_inv), .m_dten(m_dten), .m_hold(m_hold),
    .stg_per(stg_per), .stg_cmp(stg_cmp), .stg_dt(stg_dt), .rdata(reg_rdata)
  );

  pwm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(m_run), .tri_mode(m_tri),
    .period(work_per), .count(count), .cyc_end(cyc_end)
  );

  pwm_shadow #(.CNT_W(CNT_W), .DT_W(DT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .run(m_run), .hold(m_hold), .cyc_end(cyc_end),
    .stg_per(stg_per), .stg_cmp(stg_cmp), .stg_dt(stg_dt),
    .work_per(work_per), .work_cmp(work_cmp), .work_dt(work_dt)
  );

  pwm_outstage #(.CNT_W(CNT_W), .DT_W(DT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .run(m_run), .inv(m_inv), .dt_en(m_dten),
    .count(count), .cmp(work_cmp), .dt(work_dt), .pin_a(pwm_a), .pin_b(pwm_b)
  );
endmodule

// File: tb/pwm_shadow_chan_bench.sv
`timescale 1ns/1ps
module pwm_shadow_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pwm_a, pwm_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_shadow_chan u_pwm_shadow_chan (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  typedef struct packed {
    logic [7:0]  mode;
    logic [15:0] per;
    logic [15:0] cmp;
    logic [7:0]  dt;
    logic [7:0]  win;
    logic [7:0]  exp_a;
    logic [7:0]  exp_b;
  } vec_t;

  // mode bits: run=1, tri=2, inv=4, dten=8
  localparam vec_t VEC [7] = '{
    '{8'h01, 16'd9, 16'd6, 8'd0, 8'd10, 8'd4, 8'd6},   // R4 R7 sawtooth
    '{8'h05, 16'd9, 16'd6, 8'd0, 8'd10, 8'd6, 8'd4},   // R6 inverted
    '{8'h09, 16'd9, 16'd6, 8'd2, 8'd10, 8'd2, 8'd4},   // R8 dead time
    '{8'h03, 16'd8, 16'd6, 8'd0, 8'd16, 8'd5, 8'd11},  // R5 triangle
    '{8'h0B, 16'd8, 16'd6, 8'd3, 8'd16, 8'd2, 8'd8},   // R5 R8 triangle + dead time
    '{8'h01, 16'd7, 16'd0, 8'd0, 8'd8,  8'd8, 8'd0},   // R7 compare 0
    '{8'h01, 16'd7, 16'd8, 8'd0, 8'd8,  8'd0, 8'd8}    // R7 compare above period
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int len);
    logic prev;
    @(negedge clk); prev = pwm_a;
    while (!(prev == 1'b0 && pwm_a == 1'b1)) begin
      prev = pwm_a; @(negedge clk);
    end
    len = 0;
    prev = pwm_a;
    do begin
      @(negedge clk); len++;
      if (prev == 1'b0 && pwm_a == 1'b1) break;
      prev = pwm_a;
    end while (1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int v, len, na, nb, both;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 pin a", pwm_a, 0);
    check("R1 pin b", pwm_b, 0);
    rd(4'h0, v); check("R1 mode", v, 0);
    rd(4'h6, v); check("R1 work period", v, 0);

    // R2 direct write ignored
    wr(4'h0, 16'hFFFF);
    rd(4'h0, v); check("R2 mode unchanged", v, 0);

    // R3 set / clear aliases
    wr(4'h1, 16'h00FF);
    rd(4'h0, v); check("R3 set, reserved zero", v, 'h1F);
    wr(4'h2, 16'h0005);
    rd(4'h0, v); check("R3 clear", v, 'h1A);
    wr(4'h2, 16'h0000);
    rd(4'h0, v); check("R3 zero clear no effect", v, 'h1A);
    // R12 alias reads
    rd(4'h1, v); check("R12 set alias reads 0", v, 0);
    rd(4'h2, v); check("R12 clear alias reads 0", v, 0);
    wr(4'h2, 16'h001F);

    // table-driven waveform checks
    for (int i = 0; i < 7; i++) begin
      wr(4'h2, 16'h001F);
      wr(4'h3, VEC[i].per);
      wr(4'h4, VEC[i].cmp);
      wr(4'h5, 16'(VEC[i].dt));
      idle(3);
      wr(4'h1, 16'(VEC[i].mode));
      idle(50);
      na = 0; nb = 0; both = 0;
      for (int c = 0; c < int'(VEC[i].win); c++) begin
        @(negedge clk);
        if (pwm_a) na++;
        if (pwm_b) nb++;
        if ((pwm_a ^ VEC[i].mode[2]) && (pwm_b ^ VEC[i].mode[2])) both++;
      end
      check($sformatf("R7 vec%0d pin a high count", i), na, VEC[i].exp_a);
      check($sformatf("R8 vec%0d pin b high count", i), nb, VEC[i].exp_b);
      check($sformatf("R7 vec%0d no overlap", i), both, 0);
    end

    // R9 shadow update at cycle end
    wr(4'h2, 16'h001F);
    wr(4'h3, 16'd9); wr(4'h4, 16'd2); wr(4'h5, 16'd0);
    idle(3);
    wr(4'h1, 16'h0001);
    idle(20);
    measure(len); check("R4 sawtooth cycle length", len, 10);
    wr(4'h3, 16'd4);
    idle(40);
    measure(len); check("R9 new period taken", len, 5);
    rd(4'h6, v); check("R9 work period", v, 4);

    // R10 hold freezes working registers
    wr(4'h1, 16'h0010);
    wr(4'h3, 16'd9);
    idle(40);
    measure(len); check("R10 period frozen", len, 5);
    rd(4'h6, v); check("R10 work period frozen", v, 4);
    rd(4'h3, v); check("R12 staged period", v, 9);

    // R11 stopped behaviour
    wr(4'h2, 16'h0001);
    idle(3);
    check("R11 pin a passive", pwm_a, 0);
    check("R11 pin b passive", pwm_b, 0);
    rd(4'h6, v); check("R11 pass-through", v, 9);
    rd(4'h9, v); check("R11 counter held", v, 0);
    wr(4'h1, 16'h0004);
    idle(2);
    check("R6 inverted passive a", pwm_a, 1);
    check("R6 inverted passive b", pwm_b, 1);

    // R5 triangle length
    wr(4'h2, 16'h001F);
    wr(4'h3, 16'd8); wr(4'h4, 16'd6);
    idle(3);
    wr(4'h1, 16'h0003);
    idle(30);
    measure(len); check("R5 triangle cycle length", len, 16);
    wr(4'h2, 16'h001F);

    done = 1;
    summary();
    $finish;
  end
endmodule